// File: doc/BRIEF.md
# Debug-chain CPU control module

This block sits on a debug scan chain. It takes commands shifted in through a test data register and holds a two-bit control register that stalls and resets a processor core. A host shifts one frame per scan while the block is selected. On the update strobe the block decodes the last bits shifted in. An index-select command picks which internal register later writes and reads address. A write command loads that register from the data bits that came ahead of the command. No dedicated read opcode exists. At every capture the selected register is loaded into the shift path, so a no-operation scan reads the register without changing anything.

The frame is eight bits wide and is shifted least significant bit first. Bits 1:0 carry write data. Bit 2 is the register index. Bits 6:3 hold the opcode. Bit 7 is a flag that must be 0 for the frame to be meant for this module. Shorter scans, such as a five-bit no-operation, still land the command in bits 7:3, because the most recently shifted bits always sit at the top of the register.

Top module: `dbg_cpu_ctl`

## Requirements
- R1: After reset, and again after any later reset, the stall and reset outputs are 0 and register index 0 is selected.
- R2: An update whose frame has bit 7 set to 1 changes neither the outputs nor the selected index.
- R3: Opcode 0xD (frame bits 6:3) copies frame bit 2 into the register index. The index then holds across later scans until another 0xD. Index 0 is the control register. Index 1 is unimplemented and reads as zeros.
- R4: Opcode 0x9 with index 0 selected loads frame bits 1:0 into the control register on the update edge. From the next cycle, bit 0 drives the stall output and bit 1 drives the reset output.
- R5: Opcode 0x9 while index 1 is selected leaves the control register unchanged.
- R6: Opcode 0x0 (no-op), 0x3 and 0x7 (burst opcodes, not served here), and every other opcode leave all state unchanged.
- R7: While index 0 is selected, a capture makes TDO present, in order, the core's stalled input and then control bit 1. A core that stalls by itself therefore reads back as stalled.
- R8: While the module-select input is low, all strobes are ignored and TDO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_en | input | 1 | Module is selected on the chain |
| capture_dr | input | 1 | Capture strobe, loads read value |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe, executes the command |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| cpu_stalled_i | input | 1 | Core reports it is stalled |
| cpu_stall_o | output | 1 | Stall request to the core |
| cpu_rst_o | output | 1 | Reset to the core |

## Verification
The case that is hardest to reach from the ports is a write that is dropped because index 1 is selected. It can only be seen as missing output activity, and only after an earlier select scan has left the index in place. The stimulus selects index 1, issues a write that would flip both outputs, and reads back zeros. It then selects index 0 again and reads the previously written value. A second case is a stall the core raised by itself: the stalled input is driven high while the requested stall bit is 0, and the read-back must still show bit 0 set.

// File: rtl/dbg_cpu_ctl_pkg.sv
`timescale 1ns/1ps
package dbg_cpu_ctl_pkg;
    localparam int OP_W    = 4;
    localparam int IDX_W   = 1;
    localparam int DATA_W  = 2;
    localparam int FRAME_W = 1 + OP_W + IDX_W + DATA_W;
    localparam int CTRL_IDX = 0;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 4'h0,
        OP_BURST_WR = 4'h3,
        OP_BURST_RD = 4'h7,
        OP_REG_WR   = 4'h9,
        OP_REG_SEL  = 4'hD
    } op_e;

    typedef struct packed {
        logic              top_flag;
        logic [OP_W-1:0]   op;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic cmd_t decode_frame(frame_t f, logic fire);
        cmd_t c;
        c.sel  = fire && !f.top_flag && (f.op == OP_REG_SEL);
        c.wr   = fire && !f.top_flag && (f.op == OP_REG_WR);
        c.idx  = f.idx;
        c.data = f.data;
        return c;
    endfunction
endpackage

// File: rtl/dbg_shift_path.sv
`timescale 1ns/1ps
module dbg_shift_path #(
    parameter int W    = 8,
    parameter int RD_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            capture,
    input  logic            shift,
    input  logic            tdi,
    input  logic [RD_W-1:0] rd_val,
    output logic [W-1:0]    frame_o,
    output logic            tdo
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (en && capture) begin
            sr_q <= {{(W-RD_W){1'b0}}, rd_val};
        end else if (en && shift) begin
            sr_q <= {tdi, sr_q[W-1:1]};
        end
    end

    assign frame_o = sr_q;
    assign tdo     = en ? sr_q[0] : 1'b0;
endmodule

// File: rtl/dbg_cmd_decode.sv
`timescale 1ns/1ps
module dbg_cmd_decode
    import dbg_cpu_ctl_pkg::*;
(
    input  logic               en,
    input  logic               update,
    input  logic [FRAME_W-1:0] frame_i,
    output cmd_t               cmd_o
);
    frame_t f;
    assign f     = frame_t'(frame_i);
    assign cmd_o = decode_frame(f, en && update);
endmodule

// File: rtl/dbg_ctrl_regs.sv
`timescale 1ns/1ps
module dbg_ctrl_regs
    import dbg_cpu_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic              cpu_stalled_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] ctrl_q;
    logic [IDX_W-1:0]  idx_q;
    logic              ctrl_hit;

    assign ctrl_hit = (idx_q == IDX_W'(CTRL_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            idx_q  <= '0;
        end else begin
            if (cmd.sel) idx_q <= cmd.idx;
            if (cmd.wr && ctrl_hit) ctrl_q <= cmd.data;
        end
    end

    always_comb begin
        rd_val = '0;
        if (ctrl_hit) begin
            rd_val    = ctrl_q;
            rd_val[0] = cpu_stalled_i;
        end
    end

    assign ctrl_o = ctrl_q;
    assign idx_o  = idx_q;
endmodule

// File: rtl/dbg_cpu_ctl.sv
`timescale 1ns/1ps
module dbg_cpu_ctl
    import dbg_cpu_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_en,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic tdi,
    output logic tdo,
    input  logic cpu_stalled_i,
    output logic cpu_stall_o,
    output logic cpu_rst_o
);
    logic [FRAME_W-1:0] frame_w;
    logic [DATA_W-1:0]  rd_w;
    logic [DATA_W-1:0]  ctrl_w;
    logic [IDX_W-1:0]   sel_idx;
    cmd_t               cmd_w;

    dbg_shift_path #(.W(FRAME_W), .RD_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .en(sel_en), .capture(capture_dr),
        .shift(shift_dr), .tdi(tdi), .rd_val(rd_w),
        .frame_o(frame_w), .tdo(tdo)
    );

    dbg_cmd_decode u_dec (
        .en(sel_en), .update(update_dr), .frame_i(frame_w), .cmd_o(cmd_w)
    );

    dbg_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .cmd(cmd_w), .cpu_stalled_i(cpu_stalled_i),
        .ctrl_o(ctrl_w), .idx_o(sel_idx), .rd_val(rd_w)
    );

    assign cpu_stall_o = ctrl_w[0];
    assign cpu_rst_o   = ctrl_w[1];
endmodule

// File: rtl/dbg_cpu_ctl_chk.sv
`timescale 1ns/1ps
module dbg_cpu_ctl_chk
    import dbg_cpu_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sel_en,
    input logic               capture_dr,
    input logic               update_dr,
    input logic               tdo,
    input logic               cpu_stalled_i,
    input logic               cpu_stall_o,
    input logic               cpu_rst_o,
    input logic [FRAME_W-1:0] frame,
    input logic [IDX_W-1:0]   idx
);
    frame_t f;
    assign f = frame_t'(frame);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!cpu_stall_o && !cpu_rst_o && idx == '0));

    // R2
    flag_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_en && update_dr && f.top_flag) |=> ($stable({cpu_stall_o, cpu_rst_o}) && $stable(idx)));

    // R4
    write_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_en && update_dr && !f.top_flag && f.op == OP_REG_WR && idx == '0)
        |=> (cpu_stall_o == $past(f.data[0]) && cpu_rst_o == $past(f.data[1])));

    // R6
    no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(sel_en && update_dr && !f.top_flag && f.op == OP_REG_WR)
        |=> $stable({cpu_stall_o, cpu_rst_o}));

    // R7
    capture_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_en && capture_dr && idx == '0) |=> (!sel_en || tdo == $past(cpu_stalled_i)));

    // R8
    unselected_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_en |=> ($stable({cpu_stall_o, cpu_rst_o}) && $stable(idx)));
endmodule

bind dbg_cpu_ctl dbg_cpu_ctl_chk chk_i (
    .clk(clk), .rst(rst), .sel_en(sel_en), .capture_dr(capture_dr),
    .update_dr(update_dr), .tdo(tdo), .cpu_stalled_i(cpu_stalled_i),
    .cpu_stall_o(cpu_stall_o), .cpu_rst_o(cpu_rst_o),
    .frame(frame_w), .idx(sel_idx)
);

// File: tb/dbg_cpu_ctl_tb_top.sv
`timescale 1ns/1ps
module dbg_cpu_ctl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_en = 1'b1, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic tdi = 1'b0, cpu_stalled_i = 1'b0;
    logic tdo, cpu_stall_o, cpu_rst_o;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_cpu_ctl dut_i (
        .clk(clk), .rst(rst), .sel_en(sel_en), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .cpu_stalled_i(cpu_stalled_i), .cpu_stall_o(cpu_stall_o), .cpu_rst_o(cpu_rst_o)
    );

    // behavioural reference model
    logic [1:0] m_ctrl;
    logic       m_idx;
    bit         q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 2'b00; m_idx = 1'b0;
            q = {0, 0, 0, 0, 0, 0, 0, 0};
        end else if (sel_en) begin
            if (capture_dr) begin
                q = {0, 0, 0, 0, 0, 0, 0, 0};
                if (m_idx == 1'b0) begin
                    q[0] = cpu_stalled_i;
                    q[1] = m_ctrl[1];
                end
            end else if (shift_dr) begin
                void'(q.pop_front());
                q.push_back(tdi);
            end
            if (update_dr && q[7] == 1'b0) begin
                int op;
                op = q[6] * 8 + q[5] * 4 + q[4] * 2 + q[3];
                if (op == 13) m_idx = q[2];
                if (op == 9 && m_idx == 1'b0) m_ctrl = {q[1], q[0]};
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cpu_stall_o == m_ctrl[0], "R4 stall model", {7'd0, cpu_stall_o}, {7'd0, m_ctrl[0]});
            chk(cpu_rst_o == m_ctrl[1], "R4 reset model", {7'd0, cpu_rst_o}, {7'd0, m_ctrl[1]});
            chk(tdo == (sel_en ? q[0] : 1'b0), "R7/R8 tdo model", {7'd0, tdo}, {7'd0, sel_en ? q[0] : 1'b0});
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<20000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic scan(input logic [7:0] w, input int nb, output logic [7:0] got);
        got = '0;
        @(posedge clk); #1 capture_dr = 1'b1;
        @(posedge clk); #1 capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < nb; i++) begin
            tdi = w[8 - nb + i];
            @(negedge clk); got[i] = tdo;
            @(posedge clk); #1;
        end
        shift_dr = 1'b0; tdi = 1'b0; update_dr = 1'b1;
        @(posedge clk); #1 update_dr = 1'b0;
        @(negedge clk);
    endtask

    task automatic outs(input logic [1:0] exp, input string req);
        chk({cpu_rst_o, cpu_stall_o} == exp, req, {6'd0, cpu_rst_o, cpu_stall_o}, {6'd0, exp});
    endtask

    logic [7:0] g;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        outs(2'b00, "R1 reset state");

        scan(8'h00, 5, g);
        chk(g[1:0] == 2'b00, "R7 read after reset", g, 8'h00);

        scan(8'h49, 8, g);            // write 01
        outs(2'b01, "R4 write stall");
        cpu_stalled_i = 1'b1;
        scan(8'h00, 5, g);
        chk(g[4:0] == 5'b00001, "R7 read stalled", g, 8'h01);

        scan(8'h4A, 8, g);            // write 10, core still stalled
        outs(2'b10, "R4 write reset");
        scan(8'h00, 5, g);
        chk(g[1:0] == 2'b11, "R7 self stall visible", g, 8'h03);

        scan(8'hCB, 8, g);            // flag set
        outs(2'b10, "R2 flagged frame ignored");

        scan(8'h1B, 8, g);
        outs(2'b10, "R6 burst write opcode");
        scan(8'h3B, 8, g);
        outs(2'b10, "R6 burst read opcode");
        scan(8'h00, 5, g);
        outs(2'b10, "R6 nop no change");

        scan(8'h6C, 8, g);            // select index 1
        scan(8'h49, 8, g);
        outs(2'b10, "R5 write index1 ignored");
        scan(8'h00, 5, g);
        chk(g[1:0] == 2'b00, "R3 index1 persists, reads zero", g, 8'h00);

        scan(8'h68, 8, g);            // select index 0
        scan(8'h00, 5, g);
        chk(g[1:0] == 2'b11, "R3 index0 read back", g, 8'h03);
        scan(8'h48, 8, g);
        outs(2'b00, "R4 write clear");

        cpu_stalled_i = 1'b0;
        @(posedge clk); #1 sel_en = 1'b0;
        scan(8'h4B, 8, g);
        outs(2'b00, "R8 unselected write ignored");
        chk(g == 8'h00, "R8 tdo low unselected", g, 8'h00);
        @(posedge clk); #1 sel_en = 1'b1;

        scan(8'h4B, 8, g);
        outs(2'b11, "R4 write both");
        scan(8'h6C, 8, g);            // index 1, then reset must restore 0
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        outs(2'b00, "R1 later reset");
        cpu_stalled_i = 1'b1;
        scan(8'h00, 5, g);
        chk(g[0] == 1'b1, "R1 index0 after reset", g, 8'h01);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule